// File: doc/BRIEF.md
# Four-Level FSK Receive Task Engine: Frame Sync Search and Raw Symbol Capture

This block is the receive-side task engine of a four-level FSK data pump. It takes a stream of already sliced 2-bit symbols, each qualified by a valid strobe, and runs one of two host-issued tasks. The sync search keeps a sliding window over the most recent symbols. It counts how many window symbols differ from a programmable sync pattern, and it accepts the window when that count does not exceed a 2-bit tolerance. The raw read packs the next four symbols straight into one byte, without de-interleaving or error correction.

When a task completes, the engine raises a buffer-free flag and an interrupt flag and then waits for the host. The host reads the result byte if there is one, clears the interrupt with a one-cycle strobe and writes the next task. A newly written task replaces whatever task is running.

Top module: `fsk_rx_task_engine`

## Requirements
- R1: After reset, `buf_free` is 1, `irq` is 0 and `result_byte` is 0.
- R2: A `task_wr` strobe with code 01 starts a sync search and code 10 starts a raw read. Either one drives `buf_free` to 0 on the next cycle. Codes 00 and 11 abort: the engine goes idle and `buf_free` becomes 1 on the next cycle, with `irq` unchanged.
- R3: Symbol codes are +3=11, +1=10, -1=00, -3=01. The sync search compares the last 24 accepted symbols against `sync_pattern`, whose bits [47:46] hold the earliest symbol and bits [1:0] the latest. It accepts when the number of symbols that differ is less than or equal to `sync_tol`.
- R4: Starting a search empties the window, so no match can be declared before 24 symbols have been accepted since the search began.
- R5: On a sync match, `buf_free` and `irq` are both 1 in the cycle after the edge that accepted the matching symbol, and the engine goes idle.
- R6: A raw read takes the next four accepted symbols. The first lands in `result_byte[7:6]` and the fourth in `[1:0]`. The byte, `buf_free`=1 and `irq`=1 all appear in the cycle after the fourth symbol's edge.
- R7: While idle, symbols are ignored. `result_byte` changes only when a raw read completes.
- R8: An `irq_clr` strobe clears `irq` on the next cycle. If the strobe arrives in the same cycle as an event that sets `irq`, the set wins.
- R9: A task write takes priority over a symbol presented in the same cycle, and that symbol is dropped. A new task overrides a search or raw read already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| task_wr | input | 1 | One-cycle strobe that writes a task code |
| task_code | input | 2 | 01 sync search, 10 raw read, 00/11 abort |
| sync_pattern | input | 48 | Sync pattern, earliest symbol in the top bits |
| sync_tol | input | 2 | Largest accepted number of mismatched symbols |
| sym_valid | input | 1 | Qualifies `sym` for one cycle |
| sym | input | 2 | Hard-decided symbol code |
| irq_clr | input | 1 | Write-one-to-clear strobe for `irq` |
| result_byte | output | 8 | Byte captured by the last raw read |
| buf_free | output | 1 | Host may issue the next task |
| irq | output | 1 | Task-complete interrupt |

## Verification
The bench builds the block with its defaults: a 24-symbol window, 2-bit symbols and a 2-bit tolerance. This keeps every tolerance value from 0 to 3 in reach. For each tolerance it sweeps mismatch counts from 0 to 5, so the accept/reject boundary is crossed on both sides. The raw read is swept over all 256 byte values, which covers every symbol code in every byte position. Directed cases cover the flush on restart, aborts, task overrides, a symbol colliding with a task write, and the interrupt set-versus-clear collision.

// File: rtl/fsk_rx_pkg.sv
package fsk_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_RAW    = 2'd2
    } eng_state_e;

    localparam logic [1:0] CMD_ABORT = 2'b00;
    localparam logic [1:0] CMD_SYNC  = 2'b01;
    localparam logic [1:0] CMD_RAW   = 2'b10;
endpackage

// File: rtl/fsk_sym_window.sv
module fsk_sym_window #(
    parameter int WIN_LEN = 24,
    parameter int SYM_W   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       shift,
    input  logic [SYM_W-1:0]           sym_in,
    output logic [WIN_LEN*SYM_W-1:0]   win_nxt,
    output logic                       full_nxt
);
    localparam int WW = WIN_LEN * SYM_W;
    localparam int CW = $clog2(WIN_LEN + 1);
    localparam logic [CW-1:0] FILL_MAX = CW'(WIN_LEN);

    typedef struct packed {
        logic [WW-1:0] win;
        logic [CW-1:0] fill;
    } win_reg_t;

    win_reg_t q, d;

    always_comb begin
        d = q;
        if (flush) begin
            d.win  = '0;
            d.fill = '0;
        end else if (shift) begin
            d.win = {q.win[WW-SYM_W-1:0], sym_in};
            if (q.fill != FILL_MAX) d.fill = q.fill + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign win_nxt  = d.win;
    assign full_nxt = (d.fill == FILL_MAX);

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (q.fill == '0)); // R4
    AST_FILL_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !flush && q.fill != FILL_MAX) |=> (q.fill == $past(q.fill) + 1'b1)); // R4
endmodule

// File: rtl/fsk_sync_corr.sv
module fsk_sync_corr #(
    parameter int WIN_LEN = 24,
    parameter int SYM_W   = 2,
    parameter int CNT_W   = $clog2(WIN_LEN + 1)
) (
    input  logic [WIN_LEN*SYM_W-1:0] window,
    input  logic [WIN_LEN*SYM_W-1:0] pattern,
    output logic [CNT_W-1:0]         mism_cnt
);
    logic [WIN_LEN-1:0] sym_diff;

    for (genvar g = 0; g < WIN_LEN; g++) begin : g_cmp
        assign sym_diff[g] = (window[g*SYM_W +: SYM_W] != pattern[g*SYM_W +: SYM_W]);
    end

    always_comb begin
        mism_cnt = '0;
        for (int i = 0; i < WIN_LEN; i++) begin
            mism_cnt = mism_cnt + CNT_W'(sym_diff[i]);
        end
    end

    always_comb begin
        if (window == pattern) begin
            AST_EXACT_IS_ZERO: assert (mism_cnt == '0); // R3
        end
    end
endmodule

// File: rtl/fsk_rx_task_engine.sv
module fsk_rx_task_engine
    import fsk_rx_pkg::*;
#(
    parameter int WIN_LEN = 24,
    parameter int SYM_W   = 2,
    parameter int TOL_W   = 2,
    parameter int BYTE_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     task_wr,
    input  logic [1:0]               task_code,
    input  logic [WIN_LEN*SYM_W-1:0] sync_pattern,
    input  logic [TOL_W-1:0]         sync_tol,
    input  logic                     sym_valid,
    input  logic [SYM_W-1:0]         sym,
    input  logic                     irq_clr,
    output logic [BYTE_W-1:0]        result_byte,
    output logic                     buf_free,
    output logic                     irq
);
    localparam int CNT_W    = $clog2(WIN_LEN + 1);
    localparam int RAW_SYMS = BYTE_W / SYM_W;
    localparam int RC_W     = (RAW_SYMS > 1) ? $clog2(RAW_SYMS) : 1;
    localparam int ACC_W    = BYTE_W - SYM_W;
    localparam logic [RC_W-1:0] RC_LAST = RC_W'(RAW_SYMS - 1);

    typedef struct packed {
        eng_state_e        st;
        logic [BYTE_W-1:0] res;
        logic              bfree;
        logic              irq;
        logic [ACC_W-1:0]  acc;
        logic [RC_W-1:0]   rcnt;
    } eng_reg_t;

    eng_reg_t q, d;

    logic                     win_flush, win_shift, win_full;
    logic [WIN_LEN*SYM_W-1:0] win_nxt;
    logic [CNT_W-1:0]         mism_cnt;
    logic                     irq_set;

    assign win_flush = task_wr && (task_code == CMD_SYNC);
    assign win_shift = !task_wr && sym_valid && (q.st == ST_SEARCH);

    fsk_sym_window #(.WIN_LEN(WIN_LEN), .SYM_W(SYM_W)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (win_flush),
        .shift    (win_shift),
        .sym_in   (sym),
        .win_nxt  (win_nxt),
        .full_nxt (win_full)
    );

    fsk_sync_corr #(.WIN_LEN(WIN_LEN), .SYM_W(SYM_W), .CNT_W(CNT_W)) u_corr (
        .window   (win_nxt),
        .pattern  (sync_pattern),
        .mism_cnt (mism_cnt)
    );

    always_comb begin
        d       = q;
        irq_set = 1'b0;
        if (task_wr) begin
            case (task_code)
                CMD_SYNC: begin
                    d.st    = ST_SEARCH;
                    d.bfree = 1'b0;
                end
                CMD_RAW: begin
                    d.st    = ST_RAW;
                    d.bfree = 1'b0;
                    d.rcnt  = '0;
                end
                default: begin
                    d.st    = ST_IDLE;
                    d.bfree = 1'b1;
                end
            endcase
        end else if (sym_valid) begin
            case (q.st)
                ST_SEARCH: begin
                    if (win_full && (mism_cnt <= CNT_W'(sync_tol))) begin
                        d.st    = ST_IDLE;
                        d.bfree = 1'b1;
                        irq_set = 1'b1;
                    end
                end
                ST_RAW: begin
                    if (q.rcnt == RC_LAST) begin
                        d.res   = {q.acc, sym};
                        d.st    = ST_IDLE;
                        d.bfree = 1'b1;
                        irq_set = 1'b1;
                    end else begin
                        d.acc  = {q.acc[ACC_W-SYM_W-1:0], sym};
                        d.rcnt = q.rcnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
        if (irq_set)      d.irq = 1'b1;
        else if (irq_clr) d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.bfree <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign result_byte = q.res;
    assign buf_free    = q.bfree;
    assign irq         = q.irq;

    AST_TASK_TAKES_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        (task_wr && (task_code == CMD_SYNC || task_code == CMD_RAW)) |=> !buf_free); // R2
    AST_ABORT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (task_wr && (task_code == CMD_ABORT || task_code == 2'b11)) |=> (buf_free && q.st == ST_IDLE)); // R2
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_RAW) |=> $stable(result_byte)); // R7
    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && q.st == ST_IDLE) |=> !irq); // R8
    AST_IRQ_WITH_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> buf_free); // R5
    AST_NO_EARLY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SEARCH && !win_full) |=> !$rose(irq)); // R4
endmodule

// File: tb/fsk_rx_task_engine_bench.sv
module fsk_rx_task_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        task_wr = 1'b0;
    logic [1:0]  task_code = 2'b00;
    logic [47:0] sync_pattern = 48'hF5F5_3A9C_60D7;
    logic [1:0]  sync_tol = 2'd0;
    logic        sym_valid = 1'b0;
    logic [1:0]  sym = 2'b00;
    logic        irq_clr = 1'b0;
    logic [7:0]  result_byte;
    logic        buf_free;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fsk_rx_task_engine u_fsk_rx_task_engine (
        .clk(clk), .rst_n(rst_n), .task_wr(task_wr), .task_code(task_code),
        .sync_pattern(sync_pattern), .sync_tol(sync_tol), .sym_valid(sym_valid),
        .sym(sym), .irq_clr(irq_clr), .result_byte(result_byte),
        .buf_free(buf_free), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_task(input logic [1:0] code);
        @(negedge clk); task_wr = 1'b1; task_code = code;
        @(negedge clk); task_wr = 1'b0;
    endtask

    task automatic send_sym(input logic [1:0] s);
        @(negedge clk); sym_valid = 1'b1; sym = s;
        @(negedge clk); sym_valid = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    function automatic logic [1:0] pat_sym(input int j);
        return sync_pattern[47-2*j -: 2];
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 buf_free", buf_free, 1);
        check("R1 irq", irq, 0);
        check("R1 result", result_byte, 0);

        // R3/R5: tolerance sweep against mismatch count
        for (int tol = 0; tol < 4; tol++) begin
            sync_tol = 2'(tol);
            for (int k = 0; k < 6; k++) begin
                write_task(2'b01);
                check("R2 search clears buf_free", buf_free, 0);
                for (int j = 0; j < 24; j++) begin
                    logic [1:0] s;
                    s = pat_sym(j);
                    if ((j % 5 == 0) && (j / 5 < k)) s = s ^ 2'b10;
                    send_sym(s);
                    if (j == 22) check("R4 no match before full window", buf_free, 0);
                end
                check("R3 match decision", buf_free, (k <= tol) ? 1 : 0);
                check("R5 irq on match", irq, (k <= tol) ? 1 : 0);
                if (k <= tol) begin
                    clear_irq();
                    check("R8 irq cleared", irq, 0);
                end else begin
                    write_task(2'b00);
                    check("R2 abort frees", buf_free, 1);
                    check("R2 abort leaves irq", irq, 0);
                end
            end
        end

        // R4: restart flushes window
        sync_tol = 2'd0;
        write_task(2'b01);
        for (int j = 0; j < 12; j++) send_sym(pat_sym(j));
        write_task(2'b01);
        for (int j = 12; j < 24; j++) send_sym(pat_sym(j));
        check("R4 flush on restart", buf_free, 0);
        for (int j = 0; j < 24; j++) send_sym(pat_sym(j));
        check("R4 match after full refill", buf_free, 1);
        clear_irq();

        // R6: all byte values through raw read
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b;
            b = 8'(v);
            write_task(2'b10);
            send_sym(b[7:6]); send_sym(b[5:4]); send_sym(b[3:2]);
            check("R6 busy mid-read", buf_free, 0);
            send_sym(b[1:0]);
            check("R6 result", result_byte, b);
            check("R6 flags", {buf_free, irq}, 2'b11);
            clear_irq();
        end

        // R7: idle symbols ignored
        for (int j = 0; j < 4; j++) send_sym(2'b01);
        check("R7 result kept idle", result_byte, 8'hFF);
        check("R7 flags kept idle", {buf_free, irq}, 2'b10);

        // R9: symbol with task write dropped
        @(negedge clk); task_wr = 1'b1; task_code = 2'b10; sym_valid = 1'b1; sym = 2'b11;
        @(negedge clk); task_wr = 1'b0; sym_valid = 1'b0;
        send_sym(2'b00); send_sym(2'b01); send_sym(2'b10);
        check("R9 dropped symbol not counted", buf_free, 0);
        send_sym(2'b11);
        check("R9 result after collision", result_byte, 8'h1B);
        clear_irq();

        // R9: raw overrides search
        write_task(2'b01);
        for (int j = 0; j < 10; j++) send_sym(pat_sym(j));
        write_task(2'b10);
        send_sym(2'b10); send_sym(2'b00); send_sym(2'b11); send_sym(2'b01);
        check("R9 override result", result_byte, 8'h8D);
        check("R9 override flags", {buf_free, irq}, 2'b11);

        // R8: set wins over clear
        clear_irq();
        write_task(2'b10);
        send_sym(2'b01); send_sym(2'b01); send_sym(2'b01);
        @(negedge clk); sym_valid = 1'b1; sym = 2'b01; irq_clr = 1'b1;
        @(negedge clk); sym_valid = 1'b0; irq_clr = 1'b0;
        check("R8 set wins", irq, 1);
        check("R6 result 55", result_byte, 8'h55);

        // R2: code 11 aborts
        write_task(2'b01);
        write_task(2'b11);
        check("R2 code 11 aborts", buf_free, 1);
        check("R2 abort keeps irq", irq, 1);

        done = 1'b1;
        summary();
    end
endmodule